// File: doc/BRIEF.md
# Real and Protected Address Generator

This block turns a logical address, made of a 16-bit segment value and an offset, into a linear address. A mode input picks between two ways of doing this.

In real mode the segment value is multiplied by 16 and added to the low 16 bits of the offset. The sum wraps within a 20-bit, 1 MB space.

In protected mode the segment value is a selector. It picks one of two small descriptor tables, called global and local, and an entry in that table. Each entry holds a 32-bit base, a 32-bit limit and an attribute field. The full 32-bit offset is added to the base. Before the sum is accepted, the offset is checked against the limit, the table index is checked against the table size, and the entry is checked for being usable. A request that fails any of these checks produces a fault pulse instead of a valid address. The tables are filled through a simple write port.

Top module: `seg_xlate`

## Requirements
- R1: While rst_ni is low, and afterwards until a request is presented, lin_valid_o, fault_o and lin_addr_o are all zero. Reset also marks every descriptor entry as not loaded.
- R2: In real mode (prot_mode_i = 0) the result is lin_addr_o = (seg_i * 16 + offset_i[15:0]) mod 2^20. Bits 31:20 of lin_addr_o are zero, and offset_i[31:16] has no effect.
- R3: A request presented with req_valid_i = 1 at a clock edge produces its result on the outputs right after that edge, for exactly one cycle. A cycle without a request leaves lin_valid_o and fault_o low. Real-mode requests never fault.
- R4: In protected mode, selector bit 2 picks the table (0 = global, 1 = local) and selector bits 15:3 are the entry index. Selector bits 1:0 have no effect.
- R5: In protected mode, a request that passes all checks gives lin_valid_o = 1 and lin_addr_o = (base + offset_i) mod 2^32.
- R6: If offset_i is greater than the entry's limit, fault_o pulses and lin_valid_o stays low. An offset exactly equal to the limit is accepted.
- R7: In protected mode, an entry index of ENTRIES (8) or more faults, whatever the table contents.
- R8: An entry faults if it has not been written since reset. It also faults if its attribute bit 3 (present) is 0, or if its attribute bits 2:0 (type) are 0.
- R9: A write with wr_en_i = 1 stores base, limit and attribute into table wr_tbl_i at entry wr_idx_i. The new values apply to requests presented from the next cycle on. A request in the same cycle as the write sees the old entry.
- R10: lin_valid_o and fault_o are never high together, and lin_addr_o is zero whenever lin_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| seg_i | input | 16 | Segment value (real mode) or selector (protected mode) |
| offset_i | input | 32 | Offset; only bits 15:0 are used in real mode |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_tbl_i | input | 1 | Table to write: 0 = global, 1 = local |
| wr_idx_i | input | 3 | Entry to write |
| wr_base_i | input | 32 | Base address to store |
| wr_limit_i | input | 32 | Highest valid offset to store |
| wr_attr_i | input | 4 | Attribute: bit 3 present, bits 2:0 type (0 = unusable) |
| lin_valid_o | output | 1 | Linear address valid pulse |
| lin_addr_o | output | 32 | Linear address |
| fault_o | output | 1 | Translation fault pulse |

## Verification
A wrong base or limit in a stored entry shows up one cycle after the first protected request that selects that entry. It appears as a wrong address, or as a missing or spurious fault at the limit boundary. The bench therefore probes every entry of both tables at offsets just below, at and just above each limit. A mix-up in table or index decoding looks the same, so every entry is also read through all four values of the two ignored selector bits. Real-mode errors in the shift or the 20-bit wrap are seen the cycle after the request, and a sweep over spread-out segment values with edge offsets finds them.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  localparam int SEG_W      = 16;
  localparam int OFF_W      = 32;
  localparam int LIN_W      = 32;
  localparam int REAL_OFF_W = 16;
  localparam int REAL_AW    = SEG_W + 4;
  localparam int ATTR_W     = 4;
  localparam int TYPE_W     = 3;
  localparam int PRESENT_B  = 3;
  localparam int SEL_IDX_LO = 3;
  localparam int SEL_TBL_B  = 2;

  typedef struct packed {
    logic [LIN_W-1:0]  base;
    logic [OFF_W-1:0]  limit;
    logic [ATTR_W-1:0] attr;
  } desc_t;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import addr_gen_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_tbl_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  desc_t            wr_desc_i,
  input  logic             rd_tbl_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output desc_t            rd_desc_o,
  output logic             rd_loaded_o
);
  localparam int SLOTS = 2 * ENTRIES;

  desc_t      desc_q   [SLOTS];
  logic [SLOTS-1:0] loaded_q;
  logic [SLOTS-1:0] slot_we;

  for (genvar s = 0; s < SLOTS; s++) begin : g_we
    assign slot_we[s] = wr_en_i && ({wr_tbl_i, wr_idx_i} == (IDX_W+1)'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= '0;
      for (int s = 0; s < SLOTS; s++) desc_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_we[s]) begin
          desc_q[s]   <= wr_desc_i;
          loaded_q[s] <= 1'b1;
        end
      end
    end
  end

  assign rd_desc_o   = desc_q[{rd_tbl_i, rd_idx_i}];
  assign rd_loaded_o = loaded_q[{rd_tbl_i, rd_idx_i}];
endmodule

// File: rtl/real_addr_calc.sv
module real_addr_calc
  import addr_gen_pkg::*;
(
  input  logic [SEG_W-1:0]      seg_i,
  input  logic [REAL_OFF_W-1:0] off_i,
  output logic [REAL_AW-1:0]    addr_o
);
  // paragraph-aligned segment plus offset, wrapping at the 20-bit boundary
  assign addr_o = {seg_i, 4'b0000} + REAL_AW'(off_i);
endmodule

// File: rtl/prot_addr_calc.sv
module prot_addr_calc
  import addr_gen_pkg::*;
(
  input  desc_t             desc_i,
  input  logic              loaded_i,
  input  logic              in_range_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [LIN_W-1:0]  addr_o,
  output logic              fault_o
);
  logic unusable;

  assign unusable = !desc_i.attr[PRESENT_B] || (desc_i.attr[TYPE_W-1:0] == '0);
  assign fault_o  = !in_range_i || !loaded_i || unusable || (off_i > desc_i.limit);
  assign addr_o   = desc_i.base + LIN_W'(off_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import addr_gen_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             prot_mode_i,
  input  logic [15:0]      seg_i,
  input  logic [31:0]      offset_i,
  input  logic             wr_en_i,
  input  logic             wr_tbl_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_base_i,
  input  logic [31:0]      wr_limit_i,
  input  logic [3:0]       wr_attr_i,
  output logic             lin_valid_o,
  output logic [31:0]      lin_addr_o,
  output logic             fault_o
);
  localparam int SEL_IDX_W = SEG_W - SEL_IDX_LO;

  logic [SEL_IDX_W-1:0] sel_index;
  logic                 sel_tbl;
  logic                 in_range;
  desc_t                wr_desc, rd_desc;
  logic                 rd_loaded;
  logic [REAL_AW-1:0]   real_addr;
  logic [LIN_W-1:0]     prot_addr;
  logic                 prot_fault;
  logic                 nxt_valid, nxt_fault;
  logic [LIN_W-1:0]     nxt_addr;

  assign sel_index = seg_i[SEG_W-1:SEL_IDX_LO];
  assign sel_tbl   = seg_i[SEL_TBL_B];
  assign in_range  = sel_index < SEL_IDX_W'(ENTRIES);
  assign wr_desc   = '{base: wr_base_i, limit: wr_limit_i, attr: wr_attr_i};

  seg_desc_file #(.ENTRIES(ENTRIES)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_tbl_i   (wr_tbl_i),
    .wr_idx_i   (wr_idx_i),
    .wr_desc_i  (wr_desc),
    .rd_tbl_i   (sel_tbl),
    .rd_idx_i   (sel_index[IDX_W-1:0]),
    .rd_desc_o  (rd_desc),
    .rd_loaded_o(rd_loaded)
  );

  real_addr_calc u_real (
    .seg_i (seg_i),
    .off_i (offset_i[REAL_OFF_W-1:0]),
    .addr_o(real_addr)
  );

  prot_addr_calc u_prot (
    .desc_i    (rd_desc),
    .loaded_i  (rd_loaded),
    .in_range_i(in_range),
    .off_i     (offset_i),
    .addr_o    (prot_addr),
    .fault_o   (prot_fault)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_fault = 1'b0;
    nxt_addr  = '0;
    if (req_valid_i) begin
      if (!prot_mode_i) begin
        nxt_valid = 1'b1;
        nxt_addr  = LIN_W'(real_addr);
      end else if (prot_fault) begin
        nxt_fault = 1'b1;
      end else begin
        nxt_valid = 1'b1;
        nxt_addr  = prot_addr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      lin_addr_o  <= '0;
    end else begin
      lin_valid_o <= nxt_valid;
      fault_o     <= nxt_fault;
      lin_addr_o  <= nxt_addr;
    end
  end

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!lin_valid_o && !fault_o));

  a_r3_real_never_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !prot_mode_i) |=> (lin_valid_o && !fault_o));

  a_r2_real_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !prot_mode_i) |=> (lin_addr_o[LIN_W-1:REAL_AW] == '0));

  a_r7_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && prot_mode_i && (seg_i[15:3] >= 13'(ENTRIES))) |=> fault_o);

  a_r6_over_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && prot_mode_i && (offset_i > rd_desc.limit)) |=> (fault_o && !lin_valid_o));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lin_valid_o && fault_o));

  a_r10_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_valid_o |-> (lin_addr_o == '0));
endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, prot_mode_i = 1'b0;
  logic [15:0] seg_i = '0;
  logic [31:0] offset_i = '0;
  logic        wr_en_i = 1'b0, wr_tbl_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [31:0] wr_base_i = '0, wr_limit_i = '0;
  logic [3:0]  wr_attr_i = '0;
  logic        lin_valid_o, fault_o;
  logic [31:0] lin_addr_o;

  int errs = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_base  [2][N];
  logic [31:0] m_limit [2][N];
  logic [3:0]  m_attr  [2][N];
  bit          m_ld    [2][N];

  seg_xlate dut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: act v=%0b f=%0b a=%08h exp v=%0b f=%0b a=%08h",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  function automatic logic [33:0] model(bit prot, logic [15:0] seg, logic [31:0] off);
    int t, i;
    if (!prot) return {2'b10, 12'h0, 20'(({4'h0, seg} << 4) + {4'h0, off[15:0]})};
    t = int'(seg[2]);
    i = int'(seg[15:3]);
    if (i >= N) return {2'b01, 32'h0};
    if (!m_ld[t][i] || !m_attr[t][i][3] || m_attr[t][i][2:0] == 3'd0 || off > m_limit[t][i])
      return {2'b01, 32'h0};
    return {2'b10, m_base[t][i] + off};
  endfunction

  task automatic do_req(string req, bit prot, logic [15:0] seg, logic [31:0] off);
    logic [33:0] e;
    e = model(prot, seg, off);
    @(negedge clk_i);
    req_valid_i = 1'b1; prot_mode_i = prot; seg_i = seg; offset_i = off;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    chk(req, {lin_valid_o, fault_o, lin_addr_o}, e);
  endtask

  task automatic wr(int t, int i, logic [31:0] b, logic [31:0] l, logic [3:0] a);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = t[0]; wr_idx_i = 3'(i);
    wr_base_i = b; wr_limit_i = l; wr_attr_i = a;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    m_base[t][i] = b; m_limit[t][i] = l; m_attr[t][i] = a; m_ld[t][i] = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        m_base[t][i] = '0; m_limit[t][i] = '0; m_attr[t][i] = '0; m_ld[t][i] = 0;
      end
    #12;
    chk("R1 in reset", {lin_valid_o, fault_o, lin_addr_o}, 34'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after reset", {lin_valid_o, fault_o, lin_addr_o}, 34'h0);
    do_req("R8 unloaded after reset", 1, 16'h0008, 32'h0);

    // real mode: fixed cases and alias
    do_req("R2 08F1:0100", 0, 16'h08F1, 32'h0000_0100);
    chk("R2 08F1:0100 value", {2'b10, lin_addr_o}, {2'b10, 32'h0000_9010});
    do_req("R2 028F:0030", 0, 16'h028F, 32'h0000_0030);
    chk("R2 028F:0030 value", {2'b10, lin_addr_o}, {2'b10, 32'h0000_2920});
    do_req("R2 alias 28F0:0030", 0, 16'h28F0, 32'h0000_0030);
    chk("R2 alias A", {2'b10, lin_addr_o}, {2'b10, 32'h0002_8F30});
    do_req("R2 alias 28F3:0000", 0, 16'h28F3, 32'h0);
    chk("R2 alias B", {2'b10, lin_addr_o}, {2'b10, 32'h0002_8F30});
    do_req("R2 wrap FFFF:FFFF", 0, 16'hFFFF, 32'hFFFF_FFFF);
    chk("R2 wrap value", {2'b10, lin_addr_o}, {2'b10, 32'h0000_FFEF});

    for (int s = 0; s < 65536; s += 257) begin
      do_req("R2 sweep off0", 0, 16'(s), 32'h0);
      do_req("R2 sweep offF", 0, 16'(s), 32'h0000_000F);
      do_req("R2 sweep off8000", 0, 16'(s), 32'h0000_8000);
      do_req("R2 sweep offFFFF", 0, 16'(s), 32'h0000_FFFF);
      do_req("R2 sweep hi ignored", 0, 16'(s), 32'hABCD_0123);
    end

    @(negedge clk_i);
    @(posedge clk_i); #1;
    chk("R3 idle cycle", {lin_valid_o, fault_o, lin_addr_o}, 34'h0);

    // load descriptors
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        if (t == 1 && i == 6) continue;
        wr(t, i, 32'h1000_0000 * t + 32'h0012_3400 * i + 32'h55,
           32'h100 * i + 32'hFF, 4'b1001 + 4'(i % 3));
      end
    wr(0, 7, 32'hFFFF_FF00, 32'h0000_0FFF, 4'b1111);
    wr(1, 7, 32'h0000_1000, 32'hFFFF_FFFF, 4'b1010);
    wr(0, 5, 32'h0040_0000, 32'h0000_FFFF, 4'b0011);
    wr(0, 6, 32'h0050_0000, 32'h0000_FFFF, 4'b1000);

    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++)
        for (int rpl = 0; rpl < 4; rpl++) begin
          logic [15:0] sel;
          logic [31:0] lim;
          sel = {13'(i), t[0], 2'(rpl)};
          lim = m_limit[t][i];
          do_req("R4 R5 offset zero", 1, sel, 32'h0);
          do_req("R5 mid offset", 1, sel, 32'h80);
          do_req("R6 limit minus one", 1, sel, lim - 1);
          do_req("R6 at limit", 1, sel, lim);
          do_req("R6 over limit", 1, sel, lim + 1);
          do_req("R5 R6 max offset", 1, sel, 32'hFFFF_FFFF);
        end

    do_req("R5 wrap base+off", 1, 16'h0038, 32'h0000_0200);
    chk("R5 wrap value", {2'b10, lin_addr_o}, {2'b10, 32'h0000_0100});
    do_req("R8 not present", 1, 16'h0028, 32'h10);
    do_req("R8 null type", 1, 16'h0030, 32'h10);
    do_req("R8 never written", 1, 16'h0034, 32'h0);
    do_req("R7 index 8", 1, 16'h0040, 32'h0);
    do_req("R7 index 100", 1, {13'd100, 3'b100}, 32'h0);
    do_req("R7 index max", 1, 16'hFFFF, 32'h0);

    // same-cycle write and request
    begin
      logic [33:0] e_old;
      e_old = model(1, 16'h0000, 32'h10);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_tbl_i = 1'b0; wr_idx_i = 3'd0;
      wr_base_i = 32'h7700_0000; wr_limit_i = 32'h0000_00FF; wr_attr_i = 4'b1001;
      req_valid_i = 1'b1; prot_mode_i = 1'b1; seg_i = 16'h0000; offset_i = 32'h10;
      @(posedge clk_i); #1;
      wr_en_i = 1'b0; req_valid_i = 1'b0;
      chk("R9 same cycle old entry", {lin_valid_o, fault_o, lin_addr_o}, e_old);
      m_base[0][0] = 32'h7700_0000; m_limit[0][0] = 32'hFF; m_attr[0][0] = 4'b1001;
    end
    do_req("R9 next cycle new entry", 1, 16'h0000, 32'h10);
    chk("R9 new value", {2'b10, lin_addr_o}, {2'b10, 32'h7700_0010});

    @(negedge clk_i);
    @(posedge clk_i); #1;
    chk("R10 idle zero", {lin_valid_o, fault_o, lin_addr_o}, 34'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule